// File: doc/BRIEF.md
# Dual-Rail Reset Supervisor Core

This block is the clocked decision logic of a supervisor that holds a processor in reset while either of two supply rails is low, while a push-button reset is held, or after the processor stops servicing a watchdog. Two comparator flags arrive already digitised, with 1 meaning that rail is above its threshold. Together with an active-low manual reset and a watchdog strobe, they are combined into a single reset state. That state is driven out twice, once active-low and once active-high.

Every input first passes through a two-flop synchroniser. The rail flags then go through a low-going glitch filter. The manual reset and the watchdog strobe must hold a new level for a minimum number of cycles before that level is accepted. After the last reset cause goes away, the reset stays asserted for a hold-off period before it releases. The watchdog counts only while reset is released and while its enable input is high. Either edge of a qualified strobe restarts the watchdog. If it runs out, it produces a one-cycle expiry that starts a normal hold-off reset. All time constants are given in nanoseconds together with the clock frequency, and the block converts them to cycle counts by rounding up, with a minimum of 1. In the requirements below, HOLD, WD, SENSE and QUAL are those cycle counts. "After edge k" means the input changed between clock edges k and k+1.

Top module: `rail_reset_supervisor`

## Requirements
- R1: While `clr` is high, `rst_n`=0 and `rst`=1. If all inputs are good and the last edge with `clr` high is k, reset releases at edge k+2+QUAL+HOLD.
- R2: Reset is asserted whenever `mreset_n` is low, either `rail_ok` bit is 0, or the watchdog expires. It stays asserted while any of these causes remains. A `mreset_n` fall after edge k asserts reset at edge k+3+QUAL.
- R3: A `mreset_n` rise after edge k releases reset at edge k+2+QUAL+HOLD, and not one cycle earlier.
- R4: A `rail_ok[i]` fall held for at least SENSE cycles, starting after edge k, asserts reset at edge k+3+SENSE. A rise after edge k releases reset at edge k+3+HOLD.
- R5: A `rail_ok[i]` low pulse shorter than SENSE cycles has no effect on the outputs.
- R6: A rising or a falling `wdog_in` transition after edge k clears the watchdog at edge K=k+3+QUAL. With no further transition, reset asserts at edge K+WD+1.
- R7: A watchdog expiry asserts reset at edge F+1, where F is the expiry edge. Reset then releases at edge F+1+HOLD.
- R8: The watchdog is held cleared while reset is asserted. If reset releases at edge R and there is no strobe, reset reasserts at edge R+WD+1.
- R9: A `mreset_n` or `wdog_in` pulse narrower than QUAL cycles is ignored.
- R10: If any cause reasserts during the hold-off, the hold-off restarts. Release then comes HOLD cycles after that cause clears.
- R11: While `wdog_en` is 0 (after its two-flop synchroniser), the watchdog never causes a reset.
- R12: `rst` is always the exact complement of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high; forces reset asserted |
| rail_ok | input | 2 | Per-rail comparator flag, 1 = rail above threshold |
| mreset_n | input | 1 | Manual reset request, active low |
| wdog_in | input | 1 | Watchdog strobe toggled by the processor |
| wdog_en | input | 1 | Watchdog enable, 0 = watchdog disabled |
| rst_n | output | 1 | Reset out, active low |
| rst | output | 1 | Reset out, active high |

## Verification
An internal fault in this block shows only as a misplaced edge on the reset outputs, so the bench predicts the exact cycle of every transition and also checks the cycle just before it. A hold-off counter that is off by one moves the release edge by one cycle, and that is detected immediately. A filter that accepts short pulses shows up as a spurious reset about QUAL or SENSE cycles after the glitch. A watchdog that fails to clear, or that counts during reset, shows up as an early reassertion within one timeout window of roughly WD cycles.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  // Convert a duration in ns to whole clock cycles, rounding up, never below 1.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_khz, longint unsigned dur_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = clk_khz * dur_ns;
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    return (cyc == 64'd0) ? 1 : int'(cyc);
  endfunction

  // Bits needed for a counter that runs from 0 to limit-1.
  function automatic int unsigned cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (clr) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/level_qualify.sv
// Output takes a new input level only after that level has been seen for
// the configured number of consecutive samples (separate count per direction).
module level_qualify #(
  parameter int unsigned RISE_LIM = 1,
  parameter int unsigned FALL_LIM = 1,
  parameter bit          INIT     = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);
  localparam int unsigned MAXL = (RISE_LIM > FALL_LIM) ? RISE_LIM : FALL_LIM;
  localparam int unsigned CW   = rsup_pkg::cnt_width(MAXL);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_LIM - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_LIM - 1);

  logic [CW-1:0] run_cnt;
  logic          differ;
  logic [CW-1:0] run_last;

  assign differ   = (din != dout);
  assign run_last = dout ? FALL_LAST : RISE_LAST;

  always_ff @(posedge clk) begin
    if (clr) begin
      dout    <= INIT;
      run_cnt <= '0;
    end else if (!differ) begin
      run_cnt <= '0;
    end else if (run_cnt == run_last) begin
      dout    <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_FLT_NO_EARLY_CHANGE: assert property (@(posedge clk) disable iff (clr)
    (!differ || run_cnt != run_last) |=> $stable(dout)); // R9
endmodule

// File: rtl/reset_holdoff.sv
module reset_holdoff #(
  parameter int unsigned HOLD_CYC = 40
) (
  input  logic clk,
  input  logic clr,
  input  logic src_active,
  output logic rst_q
);
  localparam int unsigned   CW   = rsup_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] hold_cnt;
  logic          hold_done;

  assign hold_done = (hold_cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr || src_active) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q) begin
      if (hold_done) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  AST_SRC_FORCES_RESET: assert property (@(posedge clk) disable iff (clr)
    src_active |=> (rst_q && hold_cnt == '0)); // R2
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (clr)
    (rst_q && !hold_done) |=> rst_q); // R3
  AST_RESTART_ON_SOURCE: assert property (@(posedge clk) disable iff (clr)
    (rst_q && hold_cnt != '0 && src_active) |=> (hold_cnt == '0)); // R10
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned WD_CYC = 200
) (
  input  logic clk,
  input  logic clr,
  input  logic enable,
  input  logic kick,
  input  logic hold,
  output logic expire
);
  localparam int unsigned   CW   = rsup_pkg::cnt_width(WD_CYC);
  localparam logic [CW-1:0] LAST = CW'(WD_CYC - 1);

  logic [CW-1:0] wd_cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      wd_cnt <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (hold || !enable || kick) begin
        wd_cnt <= '0;
      end else if (wd_cnt == LAST) begin
        wd_cnt <= '0;
        expire <= 1'b1;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

  AST_WD_HELD_IN_RESET: assert property (@(posedge clk) disable iff (clr)
    hold |=> (wd_cnt == '0 && !expire)); // R8
  AST_WD_KICK_CLEARS: assert property (@(posedge clk) disable iff (clr)
    kick |=> (wd_cnt == '0 && !expire)); // R6
  AST_WD_OFF_SILENT: assert property (@(posedge clk) disable iff (clr)
    !enable |=> !expire); // R11
  AST_WD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (clr)
    expire |=> !expire); // R7
endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
  import rsup_pkg::*;
#(
  parameter longint unsigned CLK_KHZ  = 50_000,
  parameter longint unsigned HOLD_NS  = 200_000_000,
  parameter longint unsigned WDOG_NS  = 1_600_000_000,
  parameter longint unsigned SENSE_NS = 6_000,
  parameter longint unsigned QUAL_NS  = 100
) (
  input  logic       clk,
  input  logic       clr,
  input  logic [1:0] rail_ok,
  input  logic       mreset_n,
  input  logic       wdog_in,
  input  logic       wdog_en,
  output logic       rst_n,
  output logic       rst
);
  localparam int unsigned HOLD_CYC  = ns_to_cycles(CLK_KHZ, HOLD_NS);
  localparam int unsigned WD_CYC    = ns_to_cycles(CLK_KHZ, WDOG_NS);
  localparam int unsigned SENSE_CYC = ns_to_cycles(CLK_KHZ, SENSE_NS);
  localparam int unsigned QUAL_CYC  = ns_to_cycles(CLK_KHZ, QUAL_NS);
  localparam int unsigned NRAIL     = 2;
  localparam int unsigned NIN       = NRAIL + 3;

  // Synchronised inputs: [NRAIL-1:0] rails, then manual, strobe, enable.
  logic [NIN-1:0]   raw_in;
  logic [NIN-1:0]   sync_in;
  logic [NRAIL-1:0] rail_good;
  logic             mr_good;
  logic             wdi_lvl;
  logic             wdi_prev;
  logic             wd_kick;
  logic             wd_expire;
  logic             src_active;
  logic             rst_q;

  assign raw_in = {wdog_en, wdog_in, mreset_n, rail_ok};

  bit_sync #(.W(NIN)) u_sync (
    .clk  (clk),
    .clr  (clr),
    .din  (raw_in),
    .dout (sync_in)
  );

  // Rails: a low must persist SENSE_CYC samples; recovery accepted at once.
  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    level_qualify #(.RISE_LIM(1), .FALL_LIM(SENSE_CYC), .INIT(1'b0)) u_rail_q (
      .clk  (clk),
      .clr  (clr),
      .din  (sync_in[g]),
      .dout (rail_good[g])
    );
  end

  level_qualify #(.RISE_LIM(QUAL_CYC), .FALL_LIM(QUAL_CYC), .INIT(1'b0)) u_mr_q (
    .clk  (clk),
    .clr  (clr),
    .din  (sync_in[NRAIL]),
    .dout (mr_good)
  );

  level_qualify #(.RISE_LIM(QUAL_CYC), .FALL_LIM(QUAL_CYC), .INIT(1'b0)) u_wdi_q (
    .clk  (clk),
    .clr  (clr),
    .din  (sync_in[NRAIL+1]),
    .dout (wdi_lvl)
  );

  always_ff @(posedge clk) begin
    if (clr) wdi_prev <= 1'b0;
    else     wdi_prev <= wdi_lvl;
  end

  assign wd_kick = (wdi_lvl != wdi_prev);

  wdog_timer #(.WD_CYC(WD_CYC)) u_wdog (
    .clk    (clk),
    .clr    (clr),
    .enable (sync_in[NRAIL+2]),
    .kick   (wd_kick),
    .hold   (rst_q),
    .expire (wd_expire)
  );

  assign src_active = !mr_good || !(&rail_good) || wd_expire;

  reset_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk        (clk),
    .clr        (clr),
    .src_active (src_active),
    .rst_q      (rst_q)
  );

  assign rst_n = ~rst_q;
  assign rst   = rst_q;

  AST_MANUAL_HOLDS_RESET: assert property (@(posedge clk) disable iff (clr)
    !mr_good |=> (rst && !rst_n)); // R2
  AST_RAIL_HOLDS_RESET: assert property (@(posedge clk) disable iff (clr)
    !(&rail_good) |=> rst); // R4
  AST_EXPIRE_TO_RESET: assert property (@(posedge clk) disable iff (clr)
    wd_expire |=> rst); // R7
endmodule

// File: tb/tb_rail_reset_supervisor.sv
module tb_rail_reset_supervisor;
  localparam int CLK_NS = 4;           // 250 MHz
  localparam longint HOLD_NS = 160, WDOG_NS = 800, SENSE_NS = 24, QUAL_NS = 12;
  // Cycle counts restated by division of the period.
  localparam int HOLD  = int'(HOLD_NS)  / CLK_NS;
  localparam int WD    = int'(WDOG_NS)  / CLK_NS;
  localparam int SENSE = int'(SENSE_NS) / CLK_NS;
  localparam int QUAL  = int'(QUAL_NS)  / CLK_NS;

  logic clk = 1'b0;
  logic clr;
  logic [1:0] rail_ok;
  logic mreset_n, wdog_in, wdog_en;
  logic rst_n, rst;

  always #(CLK_NS/2) clk = ~clk;

  rail_reset_supervisor #(
    .CLK_KHZ(250_000), .HOLD_NS(HOLD_NS), .WDOG_NS(WDOG_NS),
    .SENSE_NS(SENSE_NS), .QUAL_NS(QUAL_NS)
  ) dut (
    .clk(clk), .clr(clr), .rail_ok(rail_ok), .mreset_n(mreset_n),
    .wdog_in(wdog_in), .wdog_en(wdog_en), .rst_n(rst_n), .rst(rst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    exp_n;
    string req;
  } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Driver side: insert expected value keyed by the edge after which it holds.
  task automatic expect_at(int at, bit exp_n, string req);
    item_t it;
    int pos;
    it.at = at; it.exp_n = exp_n; it.req = req;
    pos = 0;
    while (pos < sb.size() && sb[pos].at <= at) pos++;
    sb.insert(pos, it);
  endtask

  // Monitor: compare at the falling edge, away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rst_n !== it.exp_n || rst !== ~it.exp_n) begin   // R12 checked on every item
        fails++;
        $display("FAIL %s cyc=%0d rst_n=%b rst=%b expected rst_n=%b rst=%b",
                 it.req, cyc, rst_n, rst, it.exp_n, ~it.exp_n);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    tick(3);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, pending=%0d expected 0", sb.size());
      finish_run();
    end
  end

  initial begin
    int k, k2, k3, k4, rel, orig, f, r;
    clr = 1'b1; rail_ok = 2'b11; mreset_n = 1'b1; wdog_in = 1'b0; wdog_en = 1'b0;
    tick(2);
    // R1: reset state under clear
    k = cyc; expect_at(k + 1, 1'b0, "R1"); expect_at(k + 2, 1'b0, "R1");
    tick(3);
    clr = 1'b0; k = cyc;
    rel = k + 2 + QUAL + HOLD;
    expect_at(rel - 1, 1'b0, "R1"); expect_at(rel, 1'b1, "R1");
    drain();

    // R2/R3: manual reset assert and full hold-off release
    mreset_n = 1'b0; k = cyc;
    expect_at(k + 2 + QUAL, 1'b1, "R2"); expect_at(k + 3 + QUAL, 1'b0, "R2");
    tick(12);
    mreset_n = 1'b1; k = cyc;
    rel = k + 2 + QUAL + HOLD;
    expect_at(rel - 1, 1'b0, "R3"); expect_at(rel, 1'b1, "R3");
    drain();

    // R9: manual pulse one cycle short of the qualification width
    mreset_n = 1'b0; k = cyc;
    tick(QUAL - 1);
    mreset_n = 1'b1;
    expect_at(k + QUAL + 4, 1'b1, "R9"); expect_at(k + QUAL + 12, 1'b1, "R9");
    drain();

    // R4: brown-out on rail 0 and recovery
    rail_ok[0] = 1'b0; k = cyc;
    expect_at(k + 2 + SENSE, 1'b1, "R4"); expect_at(k + 3 + SENSE, 1'b0, "R4");
    tick(20);
    rail_ok[0] = 1'b1; k = cyc;
    rel = k + 3 + HOLD;
    expect_at(rel - 1, 1'b0, "R4"); expect_at(rel, 1'b1, "R4");
    drain();

    // R5: rail 1 glitch shorter than the filter width
    rail_ok[1] = 1'b0; k = cyc;
    tick(SENSE - 1);
    rail_ok[1] = 1'b1;
    expect_at(k + SENSE + 4, 1'b1, "R5"); expect_at(k + SENSE + 15, 1'b1, "R5");
    drain();

    // R10: a rail drop inside the hold-off restarts it
    mreset_n = 1'b0; tick(10);
    mreset_n = 1'b1; k2 = cyc;
    orig = k2 + 2 + QUAL + HOLD;
    tick(20);
    rail_ok[0] = 1'b0; k3 = cyc;
    tick(SENSE + 10);
    rail_ok[0] = 1'b1; k4 = cyc;
    rel = k4 + 3 + HOLD;
    expect_at(orig, 1'b0, "R10");
    expect_at(rel - 1, 1'b0, "R10"); expect_at(rel, 1'b1, "R10");
    if (k3 <= k2) $display("note: ordering");
    drain();

    // R2: overlapping causes, reset holds until the last one clears
    mreset_n = 1'b0; rail_ok[1] = 1'b0;
    tick(15);
    mreset_n = 1'b1;
    tick(QUAL + HOLD + 20);
    expect_at(cyc + 1, 1'b0, "R2");
    tick(2);
    rail_ok[1] = 1'b1; k = cyc;
    rel = k + 3 + HOLD;
    expect_at(rel - 1, 1'b0, "R2"); expect_at(rel, 1'b1, "R2");
    drain();

    // R6/R7/R8: watchdog kicks on both edges, expiry, restart after release
    wdog_en = 1'b1; k = cyc;
    tick(50);
    wdog_in = 1'b1; k2 = cyc;                  // rising kick
    tick(150);
    wdog_in = 1'b0; k3 = cyc;                  // falling kick
    f = k3 + 3 + QUAL + WD;                    // expiry edge
    expect_at(k + 3 + WD, 1'b1, "R6");         // first kick prevented this expiry
    expect_at(k2 + 3 + QUAL + WD + 1, 1'b1, "R6"); // second kick prevented this one
    expect_at(f, 1'b1, "R6"); expect_at(f + 1, 1'b0, "R6");
    expect_at(f + HOLD, 1'b0, "R7"); expect_at(f + 1 + HOLD, 1'b1, "R7");
    r = f + 1 + HOLD;
    expect_at(r + WD, 1'b1, "R8"); expect_at(r + WD + 1, 1'b0, "R8");
    while (cyc < r + WD + 5) tick(1);

    // R11: watchdog disabled during the reset, no later expiry
    wdog_en = 1'b0;
    rel = r + WD + 1 + HOLD;
    expect_at(rel, 1'b1, "R11"); expect_at(rel + WD + 20, 1'b1, "R11");
    drain();

    finish_run();
  end
endmodule